// File: doc/BRIEF.md
# Up/Down 8-bit Timer Counter Core

This block holds an 8-bit count. On each timer tick it clears, increments or decrements that count according to a two-bit mode. The tick is a single-cycle pulse from an outside prescaler. It only takes effect while the clock-select field is nonzero. A select of zero freezes the counter, but the count stays readable and writable.

The upper end of the count sequence (TOP) is either the all-ones value or a programmable compare value, depending on the mode. Three sequences are offered:

- a free-running up count that wraps,
- an up count that restarts from zero after reaching TOP,
- a phase-correct triangle that climbs to TOP and then falls back to zero.

A CPU write port loads the count directly and beats any count activity in the same cycle. An overflow flag marks the wrap point of each sequence. Software clears the flag by writing a one to it.

Top module: `tc8_updown`

## Requirements
- R1: After reset, the count is 0x00, the direction is up (dir_down=0) and the overflow flag is 0.
- R2: The count changes only on a cycle where tick=1 and clk_sel is nonzero, or where a CPU write occurs. With clk_sel=0, ticks are ignored and the count holds.
- R3: In mode 2'b00 (free run), each enabled tick adds one. A tick at 0xFF wraps the count to 0x00 and sets the overflow flag.
- R4: TOP is 0xFF when mode[1]=0 and top_val when mode[1]=1. at_top is high exactly when count equals TOP. at_bottom is high exactly when count is 0x00.
- R5: In mode 2'b10 (clear at TOP), an enabled tick while count equals TOP loads 0x00; any other enabled tick adds one. The flag is set only by a tick taken at 0xFF.
- R6: In modes with mode[0]=1 (phase correct, 2'b01 or 2'b11), the counter rises to TOP. A tick at or above TOP while rising makes dir_down=1 and loads count-1. While falling, a tick at 0x00 makes dir_down=0, loads 0x01 and sets the overflow flag. In any mode with mode[0]=0, dir_down is 0 from the next cycle.
- R7: When wr_en=1, count takes wr_data on the next cycle. This holds even with clk_sel=0, overrides a same-cycle tick, and sets no flag.
- R8: flag_wr=1 with flag_wr_data=1 clears the overflow flag, and flag_wr_data=0 leaves it unchanged. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Clock-select field; zero stops counting |
| tick | input | 1 | Single-cycle timer tick from prescaler |
| mode | input | 2 | Counting mode; bit 0 phase correct, bit 1 TOP from top_val |
| top_val | input | 8 | Programmable TOP value |
| wr_en | input | 1 | CPU write strobe for the count |
| wr_data | input | 8 | Value loaded by a CPU write |
| flag_wr | input | 1 | CPU write strobe for the overflow flag |
| flag_wr_data | input | 1 | Write data for the flag; one clears |
| count | output | 8 | Current count |
| at_top | output | 1 | Count equals TOP |
| at_bottom | output | 1 | Count equals zero |
| dir_down | output | 1 | Counter is currently falling |
| ovf_flag | output | 1 | Overflow flag |

## Verification
A wrong count or direction register shows on count within the very next enabled tick, because every step is plus or minus one or a reload to zero. A corrupted direction bit makes the phase-correct triangle turn at the wrong end within a single tick. An error in the flag logic shows on ovf_flag one cycle after the wrap, clear or reversal tick that should have set or cleared it. The stimulus therefore compares every port after each single clock through wraps, reloads, reversals and write collisions.

// File: rtl/tc8_updown.sv
module tc8_updown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   clk_sel,
  input  logic         tick,
  input  logic [1:0]   mode,
  input  logic [W-1:0] top_val,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         flag_wr,
  input  logic         flag_wr_data,
  output logic [W-1:0] count,
  output logic         at_top,
  output logic         at_bottom,
  output logic         dir_down,
  output logic         ovf_flag
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic         en, pc;
  logic [W-1:0] top, nxt_cnt;
  logic         nxt_dir, hit;

  assign en        = tick && (clk_sel != 3'd0);
  assign pc        = mode[0];
  assign top       = mode[1] ? top_val : MAXV;
  assign at_top    = (count == top);
  assign at_bottom = (count == ZERO);

  always_comb begin
    nxt_cnt = count;
    nxt_dir = pc & dir_down;
    hit     = 1'b0;
    if (en) begin
      if (!pc) begin
        nxt_cnt = (mode[1] && count == top) ? ZERO : count + ONE;
        hit     = (count == MAXV);
      end else if (!dir_down) begin
        if (count >= top) begin
          nxt_dir = 1'b1;
          nxt_cnt = (count == ZERO) ? ZERO : count - ONE;
        end else begin
          nxt_cnt = count + ONE;
        end
      end else begin
        if (count == ZERO) begin
          nxt_dir = 1'b0;
          hit     = 1'b1;
          nxt_cnt = (top == ZERO) ? ZERO : ONE;
        end else begin
          nxt_cnt = count - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= ZERO;
      dir_down <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        count    <= wr_data;
        dir_down <= pc & dir_down;
      end else begin
        count    <= nxt_cnt;
        dir_down <= nxt_dir;
      end
      if (hit && !wr_en)
        ovf_flag <= 1'b1;
      else if (flag_wr && flag_wr_data)
        ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tc8_updown_chk.sv
module tc8_updown_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   clk_sel,
  input logic         tick,
  input logic [1:0]   mode,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count,
  input logic         dir_down,
  input logic         ovf_flag
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !wr_en) |=> $stable(count));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clk_sel != 3'd0 && !wr_en) |=>
      (count == $past(count) + ONE || count == $past(count) - ONE || count == '0));

  p_dir_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] == 1'b0) |=> !dir_down);

  p_set_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(tick && clk_sel != 3'd0 && !wr_en));
endmodule

bind tc8_updown tc8_updown_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick(tick), .mode(mode),
  .wr_en(wr_en), .wr_data(wr_data), .count(count), .dir_down(dir_down),
  .ovf_flag(ovf_flag)
);

// File: tb/sim_tc8_updown.sv
module sim_tc8_updown;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic tick = 1'b0, wr_en = 1'b0, flag_wr = 1'b0, flag_wr_data = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] top_val = 8'd0, wr_data = 8'd0;
  logic [7:0] count;
  logic at_top, at_bottom, dir_down, ovf_flag;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tc8_updown u0 (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick(tick), .mode(mode),
    .top_val(top_val), .wr_en(wr_en), .wr_data(wr_data), .flag_wr(flag_wr),
    .flag_wr_data(flag_wr_data), .count(count), .at_top(at_top),
    .at_bottom(at_bottom), .dir_down(dir_down), .ovf_flag(ovf_flag)
  );

  // {mode, top, wr, wdata, tick, clr, exp_cnt, exp_dir, exp_ovf}
  localparam int N = 16;
  localparam logic [30:0] VEC [N] = '{
    {2'd0, 8'h00, 1'b1, 8'hFD, 1'b0, 1'b0, 8'hFD, 1'b0, 1'b0}, // R7 load
    {2'd0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'hFE, 1'b0, 1'b0}, // R3
    {2'd0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0}, // R3
    {2'd0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1}, // R3 wrap
    {2'd2, 8'h03, 1'b1, 8'h02, 1'b1, 1'b1, 8'h02, 1'b0, 1'b0}, // R7 over tick, R8 clear
    {2'd2, 8'h03, 1'b0, 8'h00, 1'b1, 1'b0, 8'h03, 1'b0, 1'b0}, // R5
    {2'd2, 8'h03, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 clear at TOP
    {2'd3, 8'h03, 1'b0, 8'h00, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0}, // R6
    {2'd3, 8'h03, 1'b0, 8'h00, 1'b1, 1'b0, 8'h02, 1'b0, 1'b0}, // R6
    {2'd3, 8'h03, 1'b0, 8'h00, 1'b1, 1'b0, 8'h03, 1'b0, 1'b0}, // R6
    {2'd3, 8'h03, 1'b0, 8'h00, 1'b1, 1'b0, 8'h02, 1'b1, 1'b0}, // R6 turn down
    {2'd3, 8'h03, 1'b0, 8'h00, 1'b1, 1'b0, 8'h01, 1'b1, 1'b0}, // R6
    {2'd3, 8'h03, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0}, // R6
    {2'd3, 8'h03, 1'b0, 8'h00, 1'b1, 1'b0, 8'h01, 1'b0, 1'b1}, // R6 turn up, flag
    {2'd3, 8'h03, 1'b0, 8'h00, 1'b0, 1'b0, 8'h01, 1'b0, 1'b1}, // R2 no tick
    {2'd1, 8'h03, 1'b0, 8'h00, 1'b1, 1'b0, 8'h02, 1'b0, 1'b1}  // R6 TOP=MAX
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [7:0] tv, input logic w,
                      input logic [7:0] wd, input logic t, input logic c, input logic cd);
    mode = m; top_val = tv; wr_en = w; wr_data = wd; tick = t;
    flag_wr = c; flag_wr_data = cd;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; flag_wr = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R4 flags at zero
    chk("R1 count", count, 8'h00);
    chk("R1 dir", {7'd0, dir_down}, 8'd0);
    chk("R1 flag", {7'd0, ovf_flag}, 8'd0);
    chk("R4 bottom", {7'd0, at_bottom}, 8'd1);
    chk("R4 top", {7'd0, at_top}, 8'd0);

    // R2 stopped: tick ignored
    step(2'd0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R2 stopped", count, 8'h00);
    // R7 write works while stopped
    step(2'd0, 8'h00, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0);
    chk("R7 stopped write", count, 8'h44);

    clk_sel = 3'd1;
    step(2'd0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < N; i++) begin
      logic [30:0] v;
      v = VEC[i];
      step(v[30:29], v[28:21], v[20], v[19:12], v[11], v[10], 1'b1);
      chk($sformatf("vec%0d count", i), count, v[9:2]);
      chk($sformatf("vec%0d dir", i), {7'd0, dir_down}, {7'd0, v[1]});
      chk($sformatf("vec%0d flag", i), {7'd0, ovf_flag}, {7'd0, v[0]});
    end

    // R8 writing zero leaves flag set
    step(2'd0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R8 zero write", {7'd0, ovf_flag}, 8'd1);
    step(2'd0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    chk("R8 clear", {7'd0, ovf_flag}, 8'd0);
    // R8 set wins over clear
    step(2'd0, 8'h00, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    step(2'd0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
    chk("R8 set wins", {7'd0, ovf_flag}, 8'd1);
    chk("R3 wrap", count, 8'h00);

    // R4 TOP from top_val in mode 2
    step(2'd2, 8'h10, 1'b1, 8'h10, 1'b0, 1'b1, 1'b1);
    chk("R4 at_top reg", {7'd0, at_top}, 8'd1);
    mode = 2'd0; #1;
    chk("R4 at_top max", {7'd0, at_top}, 8'd0);
    // R5 CTC with count above TOP wraps through MAX and sets flag
    step(2'd2, 8'h10, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0);
    step(2'd2, 8'h10, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R5 wrap count", count, 8'h00);
    chk("R5 wrap flag", {7'd0, ovf_flag}, 8'd1);

    // R6 reversal at MAX in mode 1
    step(2'd1, 8'h00, 1'b1, 8'hFE, 1'b0, 1'b1, 1'b1);
    step(2'd1, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R6 reach max", count, 8'hFF);
    step(2'd1, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R6 max turn", count, 8'hFE);
    chk("R6 max dir", {7'd0, dir_down}, 8'd1);
    chk("R6 no flag at top", {7'd0, ovf_flag}, 8'd0);
    // R6 leaving phase mode forces up
    step(2'd0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R6 dir forced up", {7'd0, dir_down}, 8'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule